// File: doc/BRIEF.md
# Dual-I/O Serial Flash Read Master

This block is the host side of a serial flash read path that uses two data lines in both directions. A request gives a 24-bit start address and a byte count and pulses `start`. The block lowers chip select and sends the read-command byte serially on lane 0. It then sends the address two bits per serial clock and inserts four filler clocks. It releases both shared lanes and collects the bit pairs returned by the flash into bytes. It presents each byte for one system cycle on `rd_valid`/`rd_data`.

The serial clock comes from the system clock through a divider. `div_half` system cycles make one half period, so the smallest ratio is two. The timing is SPI mode 0: the clock idles low, both sides sample on the rising edge, and the master changes its outputs on the falling edge. After the last requested byte the clock stops low and chip select rises. Chip select stays high for at least two serial clock periods. Then `done` pulses and `busy` drops. The device holds 1 Mbit, so only the low `ADDR_BITS` (17) address bits are meaningful. The master always sends the upper bits as zero.

Top module: `dual_io_flash_reader`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `io0_oe` and `io1_oe` are 0, and `busy`, `done` and `rd_valid` are 0.
- R2: A `start` pulse while idle with `byte_count` nonzero raises `busy` and lowers `spi_cs_n`. A `start` with `byte_count` of 0, or a `start` while `busy`, is ignored: no chip select and no change to the transfer in progress.
- R3: Serial clocks 0 to 7 carry the command byte 0xBB, MSB first, on `io0_o` with `io0_oe`=1 and `io1_oe`=0.
- R4: Clocks 8 to 19 carry the address MSB first, two bits per clock, with both enables high. `io1_o` carries the odd bit and `io0_o` carries the even bit (A23/A22 first, A1/A0 last). Address bits at position `ADDR_BITS` (17) and above are sent as 0.
- R5: Clocks 20 to 23 are filler clocks with both lanes driven to 0. Both enables drop at the falling edge that ends clock 23, before the flash drives its first data pair.
- R6: From clock 24 the master samples (`io1_i`, `io0_i`) on each rising edge as bit pairs (7,6), (5,4), (3,2), (1,0) of a byte. Each complete byte appears on `rd_data` with a one-cycle `rd_valid`, and bytes come in address order.
- R7: Exactly `byte_count` bytes are delivered, which takes 24 + 4·`byte_count` serial clocks. The clock then stays low and `spi_cs_n` rises.
- R8: `done` is a single-cycle pulse at least two serial clock periods (4·`div_half` system cycles) after `spi_cs_n` rises, and `busy` is 0 in that cycle.
- R9: Each `spi_sclk` high phase lasts exactly `div_half` system cycles. `spi_sclk` is low whenever `spi_cs_n` is high, and the lane outputs change only at falling edges while selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse |
| start_addr | input | 24 | First byte address |
| byte_count | input | CNT_W | Number of bytes to read |
| div_half | input | DIV_W | System cycles per serial clock half period (nonzero) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rd_valid | output | 1 | Received byte valid |
| rd_data | output | 8 | Received byte |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| io0_o | output | 1 | Lane 0 output value (even bits) |
| io0_oe | output | 1 | Lane 0 output enable |
| io0_i | input | 1 | Lane 0 input value |
| io1_o | output | 1 | Lane 1 output value (odd bits) |
| io1_oe | output | 1 | Lane 1 output enable |
| io1_i | input | 1 | Lane 1 input value |

## Verification
The assertions assume three things about the inputs. `div_half` is nonzero and stays constant while `busy` is high. The flash drives a lane only while the master's enable for that lane is low. Address and count are needed only in the cycle of `start`. The stimulus keeps to these by setting the divider between transfers to values from 1 to 3 only. Its flash model starts driving no earlier than the falling edge after clock 23. It also counts any cycle in which both sides drive a lane. The sweep covers every divider value in that range, several byte counts and addresses with the upper bits set, a zero-count start and a second start during a transfer.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_TAIL,
        ST_GAP
    } rd_state_e;

    localparam logic [7:0] RD_OPCODE = 8'hBB;

    // Serial clock indices where each phase begins
    localparam logic [4:0] IDX_ADDR  = 5'd8;
    localparam logic [4:0] IDX_DUMMY = 5'd20;
    localparam logic [4:0] IDX_DATA  = 5'd24;

    // Half periods of deselect before done (two full periods)
    localparam logic [1:0] GAP_LAST = 2'd3;

endpackage

// File: rtl/dio_sclk_div.sv
module dio_sclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_half,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic             wrap;

    always_comb begin
        wrap  = (cnt_q == div_half - DIV_W'(1));
        tick  = run && wrap;
        cnt_d = cnt_q;
        if (!run || wrap) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (div_half != '0)); // R9

    AST_DIV_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(div_half)); // R9

endmodule

// File: rtl/dio_rx_pack.sv
module dio_rx_pack (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       sample,
    input  logic       lane1,
    input  logic       lane0,
    output logic       byte_end,
    output logic       valid,
    output logic [7:0] data
);

    typedef struct packed {
        logic [1:0] pair;
        logic [5:0] sh;
        logic       valid;
        logic [7:0] data;
    } rx_t;

    rx_t d, q;

    always_comb begin
        d        = q;
        d.valid  = 1'b0;
        byte_end = sample && (q.pair == 2'd3);
        if (clr) begin
            d.pair = 2'd0;
        end else if (sample) begin
            d.sh   = {q.sh[3:0], lane1, lane0};
            d.pair = q.pair + 2'd1;
            if (q.pair == 2'd3) begin
                d.valid = 1'b1;
                d.data  = {q.sh, lane1, lane0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign valid = q.valid;
    assign data  = q.data;

    AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R6

    AST_NO_SAMPLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !sample); // R6

endmodule

// File: rtl/dual_io_flash_reader.sv
module dual_io_flash_reader
    import flash_rd_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int DIV_W     = 8,
    parameter int ADDR_BITS = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [23:0]      start_addr,
    input  logic [CNT_W-1:0] byte_count,
    input  logic [DIV_W-1:0] div_half,
    output logic             busy,
    output logic             done,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             spi_cs_n,
    output logic             spi_sclk,
    output logic             io0_o,
    output logic             io0_oe,
    input  logic             io0_i,
    output logic             io1_o,
    output logic             io1_oe,
    input  logic             io1_i
);

    localparam logic [23:0] ADDR_MASK =
        (ADDR_BITS >= 24) ? 24'hFFFFFF : 24'((25'd1 << ADDR_BITS) - 25'd1);

    typedef struct packed {
        rd_state_e        st;
        logic             cs_n;
        logic             sclk;
        logic [4:0]       idx;
        logic [31:0]      tx;
        logic [CNT_W-1:0] left;
        logic             last;
        logic [1:0]       gap;
        logic             done;
    } ctl_t;

    ctl_t d, q;
    logic tick, sample, byte_end;

    dio_sclk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (q.st != ST_IDLE),
        .div_half (div_half),
        .tick     (tick)
    );

    assign sample = (q.st == ST_XFER) && tick && !q.sclk && (q.idx == IDX_DATA);

    dio_rx_pack u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (q.st == ST_IDLE),
        .sample   (sample),
        .lane1    (io1_i),
        .lane0    (io0_i),
        .byte_end (byte_end),
        .valid    (rd_valid),
        .data     (rd_data)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start && (byte_count != '0)) begin
                    d.st   = ST_XFER;
                    d.cs_n = 1'b0;
                    d.sclk = 1'b0;
                    d.idx  = '0;
                    d.tx   = {RD_OPCODE, start_addr & ADDR_MASK};
                    d.left = byte_count;
                    d.last = 1'b0;
                end
            end
            ST_XFER: begin
                if (tick) begin
                    if (!q.sclk) begin
                        d.sclk = 1'b1;
                        if (byte_end) begin
                            d.left = q.left - CNT_W'(1);
                            d.last = (q.left == CNT_W'(1));
                        end
                    end else begin
                        d.sclk = 1'b0;
                        if (q.last) begin
                            d.st = ST_TAIL;
                        end else begin
                            if (q.idx != IDX_DATA) d.idx = q.idx + 5'd1;
                            d.tx = (q.idx < IDX_ADDR) ? {q.tx[30:0], 1'b0}
                                                      : {q.tx[29:0], 2'b00};
                        end
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    d.cs_n = 1'b1;
                    d.gap  = 2'd0;
                    d.st   = ST_GAP;
                end
            end
            ST_GAP: begin
                if (tick) begin
                    d.gap = q.gap + 2'd1;
                    if (q.gap == GAP_LAST) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != ST_IDLE);
    assign done     = q.done;
    assign spi_cs_n = q.cs_n;
    assign spi_sclk = q.sclk;
    assign io0_o    = (q.idx < IDX_ADDR) ? q.tx[31] : q.tx[30];
    assign io1_o    = q.tx[31];
    assign io0_oe   = (q.st == ST_XFER) && (q.idx < IDX_DATA);
    assign io1_oe   = (q.st == ST_XFER) && (q.idx >= IDX_ADDR) && (q.idx < IDX_DATA);

    AST_CS_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy); // R2

    AST_LANE1_NEEDS_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
        io1_oe |-> io0_oe); // R3

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk); // R9

    AST_VALID_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !spi_cs_n); // R6

    AST_DONE_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (spi_cs_n && $past(spi_cs_n) && !busy)); // R8

    AST_LANES_CHANGE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && $past(!spi_cs_n) && !($stable(io0_o) && $stable(io1_o)))
        |-> $fell(spi_sclk)); // R9

    AST_RELEASE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(io0_oe) |-> ($fell(spi_sclk) || spi_cs_n)); // R5

endmodule

// File: tb/dual_io_flash_reader_test.sv
module dual_io_flash_reader_test;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int DIV_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [23:0]      start_addr = '0;
    logic [CNT_W-1:0] byte_count = '0;
    logic [DIV_W-1:0] div_half = 8'd1;
    logic             busy, done, rd_valid, spi_cs_n, spi_sclk;
    logic [7:0]       rd_data;
    logic             io0_o, io0_oe, io1_o, io1_oe;
    logic             f_oe = 1'b0, f0 = 1'b0, f1 = 1'b0;
    logic             io0_i, io1_i;

    assign io0_i = f_oe ? f0 : 1'b0;
    assign io1_i = f_oe ? f1 : 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_io_flash_reader #(.CNT_W(CNT_W), .DIV_W(DIV_W), .ADDR_BITS(17)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .div_half(div_half), .busy(busy), .done(done),
        .rd_valid(rd_valid), .rd_data(rd_data), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .io0_o(io0_o), .io0_oe(io0_oe), .io0_i(io0_i),
        .io1_o(io1_o), .io1_oe(io1_oe), .io1_i(io1_i)
    );

    int total = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fdat(input logic [23:0] a);
        logic [7:0] m;
        m = a[7:0] * 8'd29;
        return m ^ a[15:8] ^ {7'd0, a[16]} ^ 8'h5A;
    endfunction

    // Flash model: captures command and address, returns data pairs
    logic [7:0]  m_op;
    logic [23:0] m_ad;
    int m_n, m_e3, m_e4, m_e5, m_rel, m_clash;

    always @(posedge clk) if ((f_oe && (io0_oe || io1_oe))) m_clash++;

    initial begin
        forever begin
            bit active;
            @(negedge spi_cs_n);
            #1;
            m_op = 0; m_ad = 0; m_n = 0; m_e3 = 0; m_e4 = 0; m_e5 = 0; m_rel = 0;
            active = 1'b1;
            while (active) begin
                @(posedge spi_sclk or posedge spi_cs_n);
                #1;
                if (spi_cs_n) active = 1'b0;
                else begin
                    if (m_n < 8) begin
                        m_op = {m_op[6:0], io0_o};
                        if (!(io0_oe && !io1_oe)) m_e3++;
                    end else if (m_n < 20) begin
                        m_ad = {m_ad[21:0], io1_o, io0_o};
                        if (!(io0_oe && io1_oe)) m_e4++;
                    end else if (m_n < 24) begin
                        if (!(io0_oe && io1_oe && !io0_o && !io1_o)) m_e5++;
                    end
                    m_n++;
                    @(negedge spi_sclk or posedge spi_cs_n);
                    #1;
                    if (spi_cs_n) active = 1'b0;
                    else if (m_n >= 24) begin
                        int dd, bb, pp;
                        logic [7:0] v;
                        if (io0_oe || io1_oe) m_rel++;
                        dd = m_n - 24; bb = dd / 4; pp = dd % 4;
                        v = fdat(m_ad + 24'(bb));
                        f1 = v[7 - 2 * pp];
                        f0 = v[6 - 2 * pp];
                        f_oe = 1'b1;
                    end
                end
            end
            f_oe = 1'b0;
        end
    end

    task automatic run(input logic [23:0] a, input int cnt, input int dv, input bit inj);
        logic [23:0] ea;
        int k, cyc, hi, hibad, cs_rise, done_at, done_cnt, busy_bad;
        logic prev_cs;
        ea = a & 24'h01FFFF;
        @(negedge clk);
        div_half = 8'(dv); start_addr = a; byte_count = 16'(cnt); start = 1'b1;
        m_clash = 0;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !spi_cs_n, "R2", "busy/select after start", {busy, spi_cs_n}, 2);
        k = 0; cyc = 0; hi = 0; hibad = 0; cs_rise = -1; done_at = -1;
        done_cnt = 0; busy_bad = 0; prev_cs = 1'b0;
        while (done_at < 0 && cyc < 20000) begin
            if (inj && cyc == 30) begin
                start_addr = 24'h000777; byte_count = 16'd9; start = 1'b1;
            end else start = 1'b0;
            @(negedge clk);
            cyc++;
            if (spi_sclk) hi++;
            else if (hi != 0) begin
                if (hi != dv) hibad++;
                hi = 0;
            end
            if (rd_valid) begin
                chk(rd_data == fdat(ea + 24'(k)), "R6", "data byte", rd_data, fdat(ea + 24'(k)));
                k++;
            end
            if (spi_cs_n && !prev_cs) cs_rise = cyc;
            prev_cs = spi_cs_n;
            if (done) begin
                done_at = cyc; done_cnt++;
                if (busy) busy_bad++;
            end
        end
        start = 1'b0;
        @(negedge clk);
        if (done) done_cnt++;
        chk(done_at >= 0, "R8", "done seen", done_at, 1);
        chk(m_op == 8'hBB, "R3", "command byte", m_op, 8'hBB);
        chk(m_e3 == 0, "R3", "command lane enables", m_e3, 0);
        chk(m_ad == ea, "R4", "address", m_ad, ea);
        chk(m_e4 == 0, "R4", "address lane enables", m_e4, 0);
        chk(m_e5 == 0, "R5", "filler lanes", m_e5, 0);
        chk(m_rel == 0 && m_clash == 0, "R5", "lane release", m_rel + m_clash, 0);
        chk(k == cnt, "R7", "byte count", k, cnt);
        chk(m_n == 24 + 4 * cnt, "R7", "serial clocks", m_n, 24 + 4 * cnt);
        chk(spi_cs_n && !spi_sclk, "R7", "deselected, clock low", {spi_cs_n, spi_sclk}, 2);
        chk(done_at - cs_rise >= 4 * dv, "R8", "deselect time", done_at - cs_rise, 4 * dv);
        chk(done_cnt == 1 && busy_bad == 0 && !busy, "R8", "done pulse", done_cnt, 1);
        chk(hibad == 0, "R9", "clock high phase", hibad, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [23:0] addrs [4];
        int counts [4];
        addrs[0] = 24'h000000; addrs[1] = 24'hFFFFFF;
        addrs[2] = 24'h0ABCDE; addrs[3] = 24'h01FFFE;
        counts[0] = 1; counts[1] = 2; counts[2] = 3; counts[3] = 5;
        repeat (3) @(negedge clk);
        chk(spi_cs_n && !spi_sclk && !io0_oe && !io1_oe, "R1", "lines in reset",
            {spi_cs_n, spi_sclk, io0_oe, io1_oe}, 8);
        chk(!busy && !done && !rd_valid, "R1", "status in reset", {busy, done, rd_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(spi_cs_n && !busy, "R1", "idle after reset", {spi_cs_n, busy}, 2);

        // Zero count is ignored
        start_addr = 24'h001234; byte_count = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (busy || !spi_cs_n) begin
                chk(1'b0, "R2", "zero count ignored", {busy, spi_cs_n}, 1);
                break;
            end
        end
        chk(!busy && spi_cs_n, "R2", "zero count left idle", {busy, spi_cs_n}, 1);

        for (int dv = 1; dv <= 3; dv++)
            for (int c = 0; c < 4; c++)
                for (int a = 0; a < 4; a++)
                    run(addrs[a], counts[c], dv, 1'b0);

        // Start during a transfer is ignored (R2)
        run(24'h00F0F0, 6, 2, 1'b1);
        run(24'h1E0003, 4, 1, 1'b1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule